// File: doc/BRIEF.md
# Flash Security Lock Access Checker

This block sits in front of an on-chip flash controller. It judges every access request against three one-way lock bits. Each request carries the following context:

- the access mode, either in-application or external host;
- the command;
- the target block, either the primary block 0 or the secondary block 1;
- the block from which the requesting code runs.

One cycle after a request strobe the block raises either a grant pulse or a reject pulse. A rejected request causes no operation.

The lock bits are held inside the block, and a programmed bit reads as 0. The block decodes the bits into a lock state for each flash block (none, soft or hard) and a security level from 1 to 4. At the top level, booting from external memory is refused.

A soft lock lets code running from a locked block program and erase the soft-locked block. Toward an external host, a soft lock acts exactly like a hard lock. A lock-program command can only clear bits. Only a chip-erase sets all of them again, and a chip-erase is always granted.

Top module: `flash_lock_guard`

## Requirements
- R1: The security level equals 1 plus the number of lock bits at 0. `ext_boot_en_o` is low only at level 4.
- R2: The block states follow the lock bits (encoding: 0 none, 1 soft, 2 hard):
  - 111: both none.
  - 110, 101 and 011: both soft.
  - 100: block 1 hard, block 0 soft.
  - 010: both soft.
  - 001 and 000: both hard.
- R3: For each request strobe, exactly one of `grant_o` and `reject_o` is high in the following cycle, for one cycle. Both are low when there is no strobe.
- R4: A request to a block that is not locked is granted. This applies to command codes 0 (read), 1 (verify), 2 (byte program), 3 (sector erase) and 4 (block erase).
- R5: A request to a hard-locked block is rejected, with one exception: an in-application read (code 0) whose source block is itself hard locked is granted.
- R6: In-application requests to a soft-locked block are handled as follows:
  - A read is granted.
  - Verify, byte program, sector erase and block erase are granted only when the source block is locked (soft or hard).
- R7: In external host mode, a soft-locked target is treated as hard locked.
- R8: At level 2, a verify (code 1) is granted in either mode.
- R9: At level 4, every command except chip-erase (code 5) and lock-program (code 6) is rejected.
- R10: A lock-program (code 6) is always granted. It sets the bits to `bits & ~lock_clr_mask_i`, so no bit ever goes from 0 to 1.
- R11: A chip-erase (code 5) is always granted and returns all three lock bits to 1.
- R12: Code 7 is always rejected and leaves the lock bits unchanged. Any rejected request leaves them unchanged.
- R13: After reset the lock bits are 111 and `grant_o` and `reject_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, one cycle per request |
| host_mode_i | input | 1 | 1 = external host, 0 = in-application |
| cmd_i | input | 3 | Command code (0..7, see requirements) |
| tgt_blk_i | input | 1 | Target block |
| src_blk_i | input | 1 | Block holding the executing code |
| lock_clr_mask_i | input | 3 | Bits to program (clear) on a lock-program |
| grant_o | output | 1 | One-cycle grant pulse |
| reject_o | output | 1 | One-cycle reject pulse |
| lock_bits_o | output | 3 | Current lock bits |
| blk0_state_o | output | 2 | Lock state of block 0 |
| blk1_state_o | output | 2 | Lock state of block 1 |
| sec_level_o | output | 3 | Security level 1..4 |
| ext_boot_en_o | output | 1 | External boot permitted |

## Verification
The bench steps through all eight lock-bit values. For each one it issues every combination of mode, command code, target block and source block, which is 512 requests. Each value is reached by a chip-erase followed by a lock-program, so the same run exercises the one-way programming path.

Sweeping the source block separates the soft-lock rule from the hard-lock rule. Sweeping the mode separates soft from hard behaviour at levels 2 and 3, where the block states are otherwise equal. Sweeping the lock-bit values separates the three level-3 combinations from one another and from level 4.

After every request the bench checks the pulse timing and the lock bits that result.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;
  localparam int LOCK_W = 3;
  localparam int CMD_W  = 3;
  localparam int LVL_W  = 3;
  localparam int LK_W   = 2;

  typedef enum logic [CMD_W-1:0] {
    CMD_READ       = 3'd0,
    CMD_VERIFY     = 3'd1,
    CMD_BYTE_PGM   = 3'd2,
    CMD_SECT_ERASE = 3'd3,
    CMD_BLK_ERASE  = 3'd4,
    CMD_CHIP_ERASE = 3'd5,
    CMD_LOCK_PGM   = 3'd6,
    CMD_RSVD       = 3'd7
  } cmd_e;

  typedef enum logic [LK_W-1:0] {
    LK_NONE = 2'd0,
    LK_SOFT = 2'd1,
    LK_HARD = 2'd2
  } lk_e;
endpackage

// File: rtl/flash_lock_decode.sv
module flash_lock_decode
  import flash_lock_pkg::*;
(
  input  logic [LOCK_W-1:0] bits_i,
  output logic [LVL_W-1:0]  level_o,
  output lk_e               blk0_o,
  output lk_e               blk1_o
);
  logic [LVL_W-1:0] zeros;

  always_comb begin
    zeros = '0;
    for (int i = 0; i < LOCK_W; i++) begin
      zeros = zeros + LVL_W'(!bits_i[i]);
    end
    level_o = zeros + LVL_W'(1);
  end

  always_comb begin
    blk0_o = LK_HARD;
    blk1_o = LK_HARD;
    case (bits_i)
      3'b111: begin blk0_o = LK_NONE; blk1_o = LK_NONE; end
      3'b110,
      3'b101,
      3'b011,
      3'b010: begin blk0_o = LK_SOFT; blk1_o = LK_SOFT; end
      3'b100: begin blk0_o = LK_SOFT; blk1_o = LK_HARD; end
      default: begin blk0_o = LK_HARD; blk1_o = LK_HARD; end
    endcase
  end
endmodule

// File: rtl/flash_lock_rules.sv
module flash_lock_rules
  import flash_lock_pkg::*;
(
  input  logic             host_i,
  input  cmd_e             cmd_i,
  input  logic             tgt_i,
  input  logic             src_i,
  input  logic [LVL_W-1:0] level_i,
  input  lk_e              blk0_i,
  input  lk_e              blk1_i,
  output logic             allow_o
);
  lk_e tgt_st, src_st, eff_st;

  always_comb begin
    tgt_st = tgt_i ? blk1_i : blk0_i;
    src_st = src_i ? blk1_i : blk0_i;
    // host sees soft locks as hard
    eff_st = (host_i && tgt_st == LK_SOFT) ? LK_HARD : tgt_st;
  end

  always_comb begin
    allow_o = 1'b0;
    if (cmd_i == CMD_RSVD) begin
      allow_o = 1'b0;
    end else if (cmd_i == CMD_CHIP_ERASE || cmd_i == CMD_LOCK_PGM) begin
      allow_o = 1'b1;
    end else if (level_i == LVL_W'(4)) begin
      allow_o = 1'b0;
    end else if (cmd_i == CMD_VERIFY && level_i == LVL_W'(2)) begin
      allow_o = 1'b1;
    end else begin
      case (eff_st)
        LK_NONE: allow_o = 1'b1;
        LK_SOFT: allow_o = (cmd_i == CMD_READ) || (src_st != LK_NONE);
        LK_HARD: allow_o = !host_i && cmd_i == CMD_READ && src_st == LK_HARD;
        default: allow_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/flash_lock_reg.sv
module flash_lock_reg
  import flash_lock_pkg::*;
#(
  parameter logic [LOCK_W-1:0] RESET_VAL = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_en_i,
  input  logic [LOCK_W-1:0] clr_mask_i,
  input  logic              erase_en_i,
  output logic [LOCK_W-1:0] bits_o
);
  logic [LOCK_W-1:0] bits_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         bits_q <= RESET_VAL;
    else if (erase_en_i) bits_q <= '1;
    else if (clr_en_i)   bits_q <= bits_q & ~clr_mask_i;
  end

  assign bits_o = bits_q;

  // R10
  one_way_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !erase_en_i |=> ((bits_q & ~$past(bits_q)) == '0));

  // R11
  erase_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_en_i |=> (bits_q == '1));

  // R12
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!erase_en_i && !clr_en_i) |=> $stable(bits_q));
endmodule

// File: rtl/flash_lock_guard.sv
module flash_lock_guard
  import flash_lock_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              host_mode_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              tgt_blk_i,
  input  logic              src_blk_i,
  input  logic [LOCK_W-1:0] lock_clr_mask_i,
  output logic              grant_o,
  output logic              reject_o,
  output logic [LOCK_W-1:0] lock_bits_o,
  output logic [LK_W-1:0]   blk0_state_o,
  output logic [LK_W-1:0]   blk1_state_o,
  output logic [LVL_W-1:0]  sec_level_o,
  output logic              ext_boot_en_o
);
  cmd_e              cmd;
  logic [LOCK_W-1:0] bits;
  logic [LVL_W-1:0]  level;
  lk_e               blk0, blk1;
  logic              allow;
  logic              grant_q, reject_q;

  assign cmd = cmd_e'(cmd_i);

  flash_lock_reg u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_en_i   (req_i && allow && cmd == CMD_LOCK_PGM),
    .clr_mask_i (lock_clr_mask_i),
    .erase_en_i (req_i && allow && cmd == CMD_CHIP_ERASE),
    .bits_o     (bits)
  );

  flash_lock_decode u_dec (
    .bits_i  (bits),
    .level_o (level),
    .blk0_o  (blk0),
    .blk1_o  (blk1)
  );

  flash_lock_rules u_rules (
    .host_i  (host_mode_i),
    .cmd_i   (cmd),
    .tgt_i   (tgt_blk_i),
    .src_i   (src_blk_i),
    .level_i (level),
    .blk0_i  (blk0),
    .blk1_i  (blk1),
    .allow_o (allow)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q  <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      grant_q  <= req_i && allow;
      reject_q <= req_i && !allow;
    end
  end

  assign grant_o       = grant_q;
  assign reject_o      = reject_q;
  assign lock_bits_o   = bits;
  assign blk0_state_o  = blk0;
  assign blk1_state_o  = blk1;
  assign sec_level_o   = level;
  assign ext_boot_en_o = (level != LVL_W'(4));

  // R3
  one_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (grant_o ^ reject_o));

  // R3
  no_req_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!grant_o && !reject_o));

  // R11
  chip_erase_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && cmd == CMD_CHIP_ERASE) |=> grant_o);

  // R12
  rsvd_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && cmd == CMD_RSVD) |=> reject_o);

  // R2
  top_level_hard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level == LVL_W'(4)) |-> (blk0 == LK_HARD && blk1 == LK_HARD));

  // R2
  base_level_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level == LVL_W'(1)) |-> (blk0 == LK_NONE && blk1 == LK_NONE));
endmodule

// File: tb/flash_lock_guard_test.sv
module flash_lock_guard_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0;
  logic       host_mode_i = 1'b0;
  logic [2:0] cmd_i = 3'd0;
  logic       tgt_blk_i = 1'b0;
  logic       src_blk_i = 1'b0;
  logic [2:0] lock_clr_mask_i = 3'd0;
  logic       grant_o, reject_o, ext_boot_en_o;
  logic [2:0] lock_bits_o, sec_level_o;
  logic [1:0] blk0_state_o, blk1_state_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  flash_lock_guard uut (.*);

  always #5 clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected block state: 0 none, 1 soft, 2 hard
  function automatic int exp_state(input logic [2:0] v, input int b);
    int z = 3 - $countones(v);
    if (z == 0) return 0;
    if (z == 1) return 1;
    if (z == 3) return 2;
    if (v == 3'b100) return (b == 1) ? 2 : 1;
    if (v == 3'b010) return 1;
    return 2;
  endfunction

  function automatic bit exp_grant(input logic [2:0] v, input bit host, input int cmd,
                                   input bit tgt, input bit src);
    int lvl = 4 - $countones(v);
    int t = exp_state(v, tgt);
    int s = exp_state(v, src);
    if (cmd == 7) return 0;
    if (cmd == 5 || cmd == 6) return 1;
    if (lvl == 4) return 0;
    if (cmd == 1 && lvl == 2) return 1;
    if (host && t == 1) t = 2;
    if (t == 0) return 1;
    if (t == 2) return (!host && cmd == 0 && s == 2);
    return (cmd == 0) || (s != 0);
  endfunction

  task automatic issue(input bit host, input int cmd, input bit tgt, input bit src,
                       input logic [2:0] mask, output bit g, output bit r, output bit tail);
    @(negedge clk_i);
    req_i = 1'b1; host_mode_i = host; cmd_i = 3'(cmd);
    tgt_blk_i = tgt; src_blk_i = src; lock_clr_mask_i = mask;
    @(negedge clk_i);
    g = grant_o; r = reject_o;
    req_i = 1'b0;
    @(negedge clk_i);
    tail = grant_o | reject_o;
  endtask

  task automatic set_bits(input logic [2:0] v);
    bit g, r, t;
    issue(1'b1, 5, 1'b0, 1'b0, 3'b000, g, r, t);
    check(g && !r && lock_bits_o == 3'b111, "R11 chip-erase restores", lock_bits_o, 7);
    if (v != 3'b111) begin
      issue(1'b0, 6, 1'b0, 1'b0, ~v, g, r, t);
      check(g && lock_bits_o == v, "R10 lock-program clears", lock_bits_o, v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit g, r, t;
    logic [2:0] expb;
    repeat (3) @(negedge clk_i);
    // R13
    check(lock_bits_o == 3'b111, "R13 reset bits", lock_bits_o, 7);
    check(!grant_o && !reject_o, "R13 reset pulses", {grant_o, reject_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(!grant_o && !reject_o, "R3 idle quiet", {grant_o, reject_o}, 0);

    for (int v = 0; v < 8; v++) begin
      for (int h = 0; h < 2; h++) begin
        for (int c = 0; c < 8; c++) begin
          for (int tg = 0; tg < 2; tg++) begin
            for (int sr = 0; sr < 2; sr++) begin
              set_bits(3'(v));
              check(sec_level_o == 3'(4 - $countones(3'(v))), "R1 level",
                    sec_level_o, 4 - $countones(3'(v)));
              check(ext_boot_en_o == (sec_level_o != 3'd4), "R1 ext boot",
                    ext_boot_en_o, sec_level_o != 3'd4);
              check(blk0_state_o == 2'(exp_state(3'(v), 0)), "R2 block 0 state",
                    blk0_state_o, exp_state(3'(v), 0));
              check(blk1_state_o == 2'(exp_state(3'(v), 1)), "R2 block 1 state",
                    blk1_state_o, exp_state(3'(v), 1));
              issue(h[0], c, tg[0], sr[0], 3'b001, g, r, t);
              // R4 R5 R6 R7 R8 R9 decision
              check(g == exp_grant(3'(v), h[0], c, tg[0], sr[0]),
                    $sformatf("R4/R5/R6/R7/R8/R9 grant v=%0d h=%0d c=%0d t=%0d s=%0d", v, h, c, tg, sr),
                    g, exp_grant(3'(v), h[0], c, tg[0], sr[0]));
              check(g ^ r, "R3 exactly one pulse", {g, r}, 1);
              check(!t, "R3 single-cycle pulse", t, 0);
              if (c == 5) expb = 3'b111;
              else if (c == 6) expb = 3'(v) & 3'b110;
              else expb = 3'(v);
              check(lock_bits_o == expb, "R10 R11 R12 bits after request", lock_bits_o, expb);
            end
          end
        end
      end
    end

    // R10: programming an already-cleared bit with a zero mask never raises bits
    set_bits(3'b000);
    issue(1'b0, 6, 1'b0, 1'b0, 3'b000, g, r, t);
    check(g && lock_bits_o == 3'b000, "R10 no bit rises", lock_bits_o, 0);
    // R12: reserved code at level 1 leaves bits
    set_bits(3'b111);
    issue(1'b0, 7, 1'b0, 1'b0, 3'b111, g, r, t);
    check(r && lock_bits_o == 3'b111, "R12 reserved rejected", lock_bits_o, 7);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule